// File: doc/BRIEF.md
# Next Program Counter Unit

This block holds the program counter of a single-cycle 32-bit core and computes the address the counter takes next. Four candidate targets compete for the counter. The first is the sequential address (PC+4), produced by a dedicated incrementer. The second is a PC-relative branch target, gated by the ALU zero flag. The third is an absolute jump target built from the upper bits of the current PC and the instruction's 26-bit index. The fourth is a register jump taken from the first source operand. A three-bit control code, supplied directly in place of a decoder, picks the behaviour for each instruction.

Alongside the counter the unit produces two values. The first is the sequential address. The second is a link value of PC+8, which a jump-and-link instruction writes back to the register file. The counter is loaded on a rising clock edge while the enable input is high, so the core or a bench can hold it in place.

Top module: `npc_unit`

## Requirements
- R1: A synchronous active-high reset loads the PC with the reset vector parameter (default 0x0000_0000); reset takes priority over enable.
- R2: While enable is low the PC holds its value on every clock edge.
- R3: The sequential output always equals PC+4 (modulo 2^32); control code 0 and the unused codes 6 and 7 load PC+4.
- R4: With code 1 (branch if equal), the PC loads PC+4 + sign_extend(instr[15:0] << 2) when zero is 1, and loads PC+4 otherwise.
- R5: With code 2 (branch if not equal), the PC loads the branch target when zero is 0, and loads PC+4 otherwise.
- R6: With code 3 (jump), the PC loads {PC[31:28], instr[25:0], 2'b00}, whatever the value of zero.
- R7: With code 4 (jump and link), the PC loads the same absolute target as code 3, whatever the value of zero.
- R8: With code 5 (register jump), the PC loads the register operand input unchanged.
- R9: The link output always equals PC+8 (modulo 2^32).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | PC update enable |
| instr | input | 32 | Fetched instruction word |
| rs_val | input | 32 | First register operand, used as the register-jump target |
| zero | input | 1 | ALU zero flag |
| ctrl | input | 3 | Control code: 0 seq, 1 beq, 2 bne, 3 j, 4 jal, 5 jr, 6-7 seq |
| pc | output | 32 | Registered program counter |
| pc_plus4 | output | 32 | Sequential address, PC+4 |
| link | output | 32 | Return address, PC+8 |

## Verification
The bench drives negative branch offsets. A design that zero-extended the offset, or added it before shifting, would jump forward or land on the wrong word. It places the counter near 0xFFFF_FFFC and in a high region, so that both the wrap of the adders and the four region bits kept by the absolute jump are tested. A design that took those four bits from PC+4 instead of the PC would fail at the region boundary. The bench also toggles the zero flag under jumps and under the unused codes, and stalls with enable low, so that a design taking a jump conditionally or updating while stalled produces a counter that differs from the model.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [2:0] {
    NPC_SEQ = 3'd0,
    NPC_BEQ = 3'd1,
    NPC_BNE = 3'd2,
    NPC_J   = 3'd3,
    NPC_JAL = 3'd4,
    NPC_JR  = 3'd5
  } npc_op_e;

  typedef enum logic [1:0] {
    SRC_SEQ = 2'd0,
    SRC_BR  = 2'd1,
    SRC_ABS = 2'd2,
    SRC_REG = 2'd3
  } npc_src_e;
endpackage

// File: rtl/npc_targets.sv
module npc_targets #(
  parameter int XLEN = 32,
  parameter int OFFW = 16,
  parameter int IDXW = 26
) (
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] instr,
  output logic [XLEN-1:0] seq,
  output logic [XLEN-1:0] br_tgt,
  output logic [XLEN-1:0] abs_tgt,
  output logic [XLEN-1:0] lnk
);
  localparam int REGW = XLEN - IDXW - 2;

  function automatic logic [XLEN-1:0] f_br(input logic [XLEN-1:0] base,
                                           input logic [OFFW-1:0] off);
    logic [OFFW+1:0] sh;
    sh = {off, 2'b00};
    return base + {{(XLEN-OFFW-2){sh[OFFW+1]}}, sh};
  endfunction

  function automatic logic [XLEN-1:0] f_abs(input logic [XLEN-1:0] cur,
                                            input logic [IDXW-1:0] idx);
    return {cur[XLEN-1 -: REGW], idx, 2'b00};
  endfunction

  assign seq     = pc + XLEN'(4);
  assign lnk     = pc + XLEN'(8);
  assign br_tgt  = f_br(seq, instr[OFFW-1:0]);
  assign abs_tgt = f_abs(pc, instr[IDXW-1:0]);
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
(
  input  logic [2:0] ctrl,
  input  logic       zero,
  output npc_src_e   src
);
  always_comb begin
    case (ctrl)
      NPC_BEQ: src = zero ? SRC_BR : SRC_SEQ;
      NPC_BNE: src = zero ? SRC_SEQ : SRC_BR;
      NPC_J, NPC_JAL: src = SRC_ABS;
      NPC_JR: src = SRC_REG;
      default: src = SRC_SEQ;
    endcase
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter logic [31:0] RESET_VEC = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic [31:0] instr,
  input  logic [31:0] rs_val,
  input  logic        zero,
  input  logic [2:0]  ctrl,
  output logic [31:0] pc,
  output logic [31:0] pc_plus4,
  output logic [31:0] link
);
  localparam int XLEN = 32;

  logic [XLEN-1:0] seq_w, br_w, abs_w, lnk_w, nxt;
  npc_src_e src_w;
  logic taken_w;

  npc_targets #(.XLEN(XLEN), .OFFW(16), .IDXW(26)) u_tg (
    .pc(pc), .instr(instr), .seq(seq_w), .br_tgt(br_w),
    .abs_tgt(abs_w), .lnk(lnk_w)
  );

  npc_select u_sel (.ctrl(ctrl), .zero(zero), .src(src_w));

  assign taken_w = (src_w != SRC_SEQ);

  always_comb begin
    case (src_w)
      SRC_BR:  nxt = br_w;
      SRC_ABS: nxt = abs_w;
      SRC_REG: nxt = rs_val;
      default: nxt = seq_w;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     pc <= RESET_VEC;
    else if (en) pc <= nxt;
  end

  assign pc_plus4 = seq_w;
  assign link     = lnk_w;

  AST_RESET_VEC: assert property (@(posedge clk) rst |=> pc == RESET_VEC); // R1
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst) !en |=> $stable(pc)); // R2
  AST_SEQ_UNTAKEN: assert property (@(posedge clk) disable iff (rst)
    (en && !taken_w) |=> pc == $past(pc_plus4)); // R3
  AST_JR_LOAD: assert property (@(posedge clk) disable iff (rst)
    (en && ctrl == 3'd5) |=> pc == $past(rs_val)); // R8
  AST_JUMP_REGION: assert property (@(posedge clk) disable iff (rst)
    (en && (ctrl == 3'd3 || ctrl == 3'd4)) |=> pc[31:28] == $past(pc[31:28])); // R6
  AST_LINK_GAP: assert property (@(posedge clk) link - pc_plus4 == 32'd4); // R9
endmodule

// File: tb/npc_unit_test.sv
module npc_unit_test;
  logic clk = 0, rst = 1, en = 0, zero = 0;
  logic [31:0] instr = 0, rs_val = 0;
  logic [2:0] ctrl = 0;
  wire [31:0] pc, pc_plus4, link;
  int checks = 0, errors = 0;
  longint unsigned mpc;

  always #2.5 clk = ~clk;

  npc_unit uut (.clk(clk), .rst(rst), .en(en), .instr(instr), .rs_val(rs_val),
                .zero(zero), .ctrl(ctrl), .pc(pc), .pc_plus4(pc_plus4), .link(link));

  function automatic longint unsigned model_next(longint unsigned p);
    longint signed off;
    longint unsigned s;
    s = (p + 4) % 64'h1_0000_0000;
    off = longint'($signed(instr[15:0])) * 4;
    case (ctrl)
      1: return zero ? (s + off) & 64'hFFFF_FFFF : s;
      2: return !zero ? (s + off) & 64'hFFFF_FFFF : s;
      3, 4: return (p / 64'h1000_0000) * 64'h1000_0000 + instr[25:0] * 4;
      5: return rs_val;
      default: return s;
    endcase
  endfunction

  task automatic chk(string r, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", r, act, exp);
    end
  endtask

  function automatic string tag_of();
    case (ctrl)
      1: return "R4"; 2: return "R5"; 3: return "R6";
      4: return "R7"; 5: return "R8"; default: return "R3";
    endcase
  endfunction

  task automatic step(bit e, logic [2:0] c, logic z, logic [31:0] ins, logic [31:0] rv);
    string t;
    en = e; ctrl = c; zero = z; instr = ins; rs_val = rv;
    #1;
    chk("R3", pc_plus4, (mpc + 4) & 64'hFFFF_FFFF);
    chk("R9", link, (mpc + 8) & 64'hFFFF_FFFF);
    t = e ? tag_of() : "R2";
    if (e) mpc = model_next(mpc);
    @(posedge clk); #1;
    chk(t, pc, mpc);
  endtask

  task automatic jump_to(logic [31:0] a);
    step(1, 5, 0, 0, a);
  endtask

  initial begin
    fork
      begin #900000; errors++; $display("FAIL watchdog"); end
      begin
        @(posedge clk); @(posedge clk); #1;
        rst = 0; mpc = 0;
        chk("R1", pc, 0);
        step(1, 0, 0, 32'h1234, 0);
        step(1, 0, 1, 0, 0);
        step(0, 3, 1, 32'h03FF_FFFF, 0);
        step(0, 5, 0, 0, 32'hDEAD_BEE0);
        step(1, 1, 1, 32'h0000_0010, 0);
        step(1, 1, 0, 32'h0000_0010, 0);
        step(1, 1, 1, 32'h0000_FFFE, 0);
        step(1, 2, 0, 32'h0000_8000, 0);
        step(1, 2, 1, 32'h0000_8000, 0);
        step(1, 2, 0, 32'h0000_7FFF, 0);
        jump_to(32'hFFFF_FFFC);
        step(1, 0, 0, 0, 0);
        jump_to(32'h7FFF_FFF8);
        step(1, 1, 1, 32'h0000_0001, 0);
        jump_to(32'h8FFF_FFF0);
        step(1, 3, 0, 32'h0123_4567, 0);
        jump_to(32'hEFFF_FFFC);
        step(1, 4, 1, 32'hFFFF_FFFF, 0);
        step(1, 3, 1, 32'h0000_0040, 0);
        step(1, 4, 0, 32'h0200_0000, 0);
        step(1, 6, 1, 32'hFFFF_FFFF, 32'h5555_5554);
        step(1, 7, 0, 32'h0000_8000, 32'hAAAA_AAA8);
        step(1, 5, 1, 32'h0C00_0000, 32'h1357_9BDC);
        for (int i = 0; i < 200; i++)
          step(1, 3'(($urandom % 8)), 1'($urandom % 2), $urandom, $urandom);
        rst = 1; en = 0;
        @(posedge clk); #1;
        rst = 0; mpc = 0;
        chk("R1", pc, 0);
        en = 1; rst = 1; ctrl = 5; rs_val = 32'h4444_4444;
        @(posedge clk); #1;
        rst = 0; en = 0;
        chk("R1", pc, 0);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule